// File: doc/BRIEF.md
# Software-Increment Event Counter Bank

This block holds a bank of 32-bit event counters. Each counter has its own event-select code and its own enable. The only way a counter counts is through a write-only software-increment register of 64 bits. In that register, bit m of a written word asks counter m to advance by one. The request takes effect only when counter m is implemented and enabled, and only when its event select holds the software-increment code (zero by default). Bits 31 and above carry no counter and are dropped.

A single write may set several bits at once. Every matching counter then advances on the same clock edge. Software can also load a counter directly through a shared data word and a per-counter load strobe. When a load and an increment hit the same counter in the same cycle, the load wins. A counter that steps past its all-ones value wraps to zero, and the block raises a one-cycle overflow pulse for that counter in the same cycle in which the wrapped value appears.

Top module: `swinc_counter_bank`

## Requirements
- R1: After reset every counter output is zero and every overflow pulse is low.
- R2: Bits 63 down to 31 of an increment write have no effect on any counter.
- R3: A zero in bit m of an increment write leaves counter m unchanged.
- R4: A one in bit m (m below NUM_CTR) with the write strobe high, enable m high and event select m equal to 0x00 makes counter m read one higher on the next cycle.
- R5: When event select m differs from 0x00, bit m of an increment write leaves counter m unchanged.
- R6: When enable m is low, bit m of an increment write leaves counter m unchanged.
- R7: Counter slots with index at or above NUM_CTR ignore their bit and always read zero.
- R8: All counters that qualify in one increment write advance on the same clock edge.
- R9: When load strobe m is high, counter m takes the load data on the next cycle, whether or not an increment for m arrives in the same cycle.
- R10: An increment of a counter at 0xFFFFFFFF gives zero, and the overflow bit of that counter is high for exactly that one following cycle.
- R11: With the increment write strobe low, the increment data has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_wr_en | input | 1 | Increment register write strobe |
| inc_wr_data | input | 64 | Increment register write word; bit m targets counter m |
| ctr_en | input | 31 | Per-counter enable |
| evt_sel | input | 31*EVT_W | Per-counter event select, counter m in bits [m*EVT_W +: EVT_W] |
| cnt_wr_en | input | 31 | Per-counter direct load strobe |
| cnt_wr_data | input | CNT_W | Shared direct load value |
| cnt_val | output | 31*CNT_W | Counter values, counter m in bits [m*CNT_W +: CNT_W] |
| ovf_pulse | output | 31 | Per-counter one-cycle wrap pulse |

## Verification
The hardest case to reach from the ports is the wrap. Counting up from zero to 2^32 by software increments alone is far out of reach. So the bench loads 0xFFFFFFFF through the direct load path and then increments. It checks the zero value and the one-cycle pulse, and it also checks that the pulse drops on the next idle cycle. The bench also drives a load and an increment into the same counter in one cycle, and a load of all-ones into one counter while an increment hits it, to show that the load wins and that no pulse follows.

// File: rtl/swinc_counter_bank.sv
module swinc_counter_bank #(
  parameter int NUM_CTR   = 6,
  parameter int CNT_W     = 32,
  parameter int EVT_W     = 10,
  parameter int SWINC_EVT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc_wr_en,
  input  logic [63:0]            inc_wr_data,
  input  logic [30:0]            ctr_en,
  input  logic [31*EVT_W-1:0]    evt_sel,
  input  logic [30:0]            cnt_wr_en,
  input  logic [CNT_W-1:0]       cnt_wr_data,
  output logic [31*CNT_W-1:0]    cnt_val,
  output logic [30:0]            ovf_pulse
);
  localparam int SLOTS = 31;
  localparam logic [EVT_W-1:0] SW_CODE = EVT_W'(SWINC_EVT);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [SLOTS-1:0] req;
  assign req = inc_wr_en ? inc_wr_data[SLOTS-1:0] : '0;

  logic unused_sink;
  assign unused_sink = ^{inc_wr_data[63:SLOTS], evt_sel, ctr_en, cnt_wr_en};

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_CTR) begin : g_ctr
      logic [CNT_W-1:0] cnt_q;
      logic             ovf_q;
      logic             step;
      assign step = req[i] & ctr_en[i] & (evt_sel[i*EVT_W +: EVT_W] == SW_CODE);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
          ovf_q <= 1'b0;
        end else begin
          ovf_q <= 1'b0;
          if (cnt_wr_en[i]) begin
            cnt_q <= cnt_wr_data;
          end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            ovf_q <= (cnt_q == CNT_TOP);
          end
        end
      end

      assign cnt_val[i*CNT_W +: CNT_W] = cnt_q;
      assign ovf_pulse[i]              = ovf_q;
    end else begin : g_absent
      assign cnt_val[i*CNT_W +: CNT_W] = '0;
      assign ovf_pulse[i]              = 1'b0;
    end
  end
endmodule

// File: rtl/swinc_counter_bank_chk.sv
module swinc_counter_bank_chk #(
  parameter int NUM_CTR   = 6,
  parameter int CNT_W     = 32,
  parameter int EVT_W     = 10,
  parameter int SWINC_EVT = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inc_wr_en,
  input logic [63:0]         inc_wr_data,
  input logic [30:0]         ctr_en,
  input logic [31*EVT_W-1:0] evt_sel,
  input logic [30:0]         cnt_wr_en,
  input logic [CNT_W-1:0]    cnt_wr_data,
  input logic [31*CNT_W-1:0] cnt_val,
  input logic [30:0]         ovf_pulse
);
  localparam logic [EVT_W-1:0] SW_CODE = EVT_W'(SWINC_EVT);

  a_r1_r2_reserved_only: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_wr_en && inc_wr_data[30:0] == '0 && cnt_wr_en == '0) |=> $stable(cnt_val));

  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_wr_en && cnt_wr_en == '0) |=> $stable(cnt_val));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_wr_en && inc_wr_data[i] && ctr_en[i] && evt_sel[i*EVT_W +: EVT_W] == SW_CODE
       && !cnt_wr_en[i])
      |=> cnt_val[i*CNT_W +: CNT_W] == $past(cnt_val[i*CNT_W +: CNT_W]) + 1'b1);

    a_r5_other_event: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sel[i*EVT_W +: EVT_W] != SW_CODE && !cnt_wr_en[i])
      |=> $stable(cnt_val[i*CNT_W +: CNT_W]));

    a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_en[i] && !cnt_wr_en[i]) |=> $stable(cnt_val[i*CNT_W +: CNT_W]));

    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en[i] |=> cnt_val[i*CNT_W +: CNT_W] == $past(cnt_wr_data));

    a_r10_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[i] |-> cnt_val[i*CNT_W +: CNT_W] == '0);

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[i] |=> !ovf_pulse[i] || $past(cnt_val[i*CNT_W +: CNT_W]) == '1);
  end

  for (genvar j = NUM_CTR; j < 31; j++) begin : g_abs
    a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_val[j*CNT_W +: CNT_W] == '0 && !ovf_pulse[j]);
  end
endmodule

bind swinc_counter_bank swinc_counter_bank_chk #(
  .NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .EVT_W(EVT_W), .SWINC_EVT(SWINC_EVT)
) chk_i (.*);

// File: tb/swinc_counter_bank_tb_top.sv
module swinc_counter_bank_tb_top;
  localparam int N  = 6;
  localparam int CW = 32;
  localparam int EW = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            inc_wr_en = 1'b0;
  logic [63:0]     inc_wr_data = '0;
  logic [30:0]     ctr_en = '0;
  logic [31*EW-1:0] evt_sel = '0;
  logic [30:0]     cnt_wr_en = '0;
  logic [CW-1:0]   cnt_wr_data = '0;
  logic [31*CW-1:0] cnt_val;
  logic [30:0]     ovf_pulse;

  always #2.5 clk = ~clk;

  swinc_counter_bank #(.NUM_CTR(N), .CNT_W(CW), .EVT_W(EW), .SWINC_EVT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .inc_wr_en(inc_wr_en), .inc_wr_data(inc_wr_data),
    .ctr_en(ctr_en), .evt_sel(evt_sel), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_data(cnt_wr_data), .cnt_val(cnt_val), .ovf_pulse(ovf_pulse));

  int unsigned m_cnt [31];
  bit          m_ovf [31];
  int          n_chk = 0;
  int          n_bad = 0;
  string       tag = "R1";
  bit          done = 1'b0;

  task automatic compare();
    for (int i = 0; i < 31; i++) begin
      n_chk++;
      if (cnt_val[i*CW +: CW] !== m_cnt[i] || ovf_pulse[i] !== m_ovf[i]) begin
        n_bad++;
        $display("FAIL %s ctr%0d: got cnt=%h ovf=%b, expected cnt=%h ovf=%b",
                 tag, i, cnt_val[i*CW +: CW], ovf_pulse[i], m_cnt[i], m_ovf[i]);
      end
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < 31; i++) begin
      m_ovf[i] = 1'b0;
      if (i < N) begin
        if (cnt_wr_en[i]) m_cnt[i] = cnt_wr_data;
        else if (inc_wr_en && inc_wr_data[i] && ctr_en[i] && evt_sel[i*EW +: EW] == 0) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) m_ovf[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
    end
  endtask

  task automatic step(input bit we, input logic [63:0] d,
                      input logic [30:0] lw, input logic [CW-1:0] ld);
    inc_wr_en   = we;
    inc_wr_data = d;
    cnt_wr_en   = lw;
    cnt_wr_data = ld;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0);
  endtask

  initial begin
    for (int i = 0; i < 31; i++) begin m_cnt[i] = 0; m_ovf[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; compare();
    ctr_en = '1;

    tag = "R4"; step(1'b1, 64'h1, '0, '0); step(1'b1, 64'h1, '0, '0);
    tag = "R3"; step(1'b1, 64'h0, '0, '0);
    tag = "R2"; step(1'b1, 64'hFFFF_FFFF_8000_0000, '0, '0);
    tag = "R5"; evt_sel[1*EW +: EW] = 10'h005; step(1'b1, 64'h2, '0, '0);
    evt_sel[1*EW +: EW] = '0;
    tag = "R6"; ctr_en[2] = 1'b0; step(1'b1, 64'h4, '0, '0); ctr_en[2] = 1'b1;
    tag = "R7"; step(1'b1, 64'h7FFF_FFC0, '0, '0);
    tag = "R8"; step(1'b1, 64'h3F, '0, '0); step(1'b1, 64'h2A, '0, '0);
    tag = "R11"; step(1'b0, '1, '0, '0);
    tag = "R9"; step(1'b1, 64'h8, 31'h8, 32'd100);
    step(1'b1, 64'h10, 31'h10, 32'hFFFF_FFFF);
    tag = "R10"; step(1'b1, 64'h10, '0, '0); idle();
    step(1'b0, '0, 31'h21, 32'hFFFF_FFFE);
    step(1'b1, 64'h21, '0, '0); step(1'b1, 64'h21, '0, '0); idle();

    tag = "R8";
    begin
      logic [63:0] lf = 64'hACE1_1234_5678_9ABC;
      for (int k = 0; k < 200; k++) begin
        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
        evt_sel[(k % N)*EW +: EW] = (lf[3:0] == 4'h0) ? 10'h011 : '0;
        ctr_en[(k+1) % N] = lf[5] | lf[6];
        step(lf[7] | lf[8], lf, (lf[9] && lf[10]) ? lf[40:10] : '0, lf[63:32]);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule